// File: doc/BRIEF.md
# Debug Exception Reporting Unit

This block sits beside the exception logic of a 64-bit core and turns debug events into exception requests. Three sources feed it: a single-step completion strobe that carries the address of the instruction just retired, an instruction-breakpoint hit strobe, and a data-watchpoint hit strobe that carries the data address that matched. A feature-enable input selects whether the extended debug reporting is active. Each event becomes exactly one request. A request is either a trace exception or a data storage interrupt. It comes with a 64-bit status word that the core merges into its saved machine-state image. Along with the request, the block loads the sampled-instruction-address, data-address and data-status registers.

Requests leave on a valid/ready stream. Once the request valid output rises, it stays high until the core accepts it by holding ready high at a rising clock edge, and its kind and status fields stay constant until then. Events that arrive while a request is stalled are kept in one pending slot per source. A second strobe from a source whose slot is already full is merged into the pending event, and the earliest captured data is kept. The core may hold ready high at all times, and a new request can then issue on the same edge that accepts the previous one. Status bit positions use big-endian numbering: bit n is vector index 63-n.

The address comparators, the pipeline flush and the vectoring to the handler are outside this block.

Top module: `dbg_excp_unit`

## Requirements
- R1: After reset, req_valid is 0 and siar, dar and dsisr are all zero.
- R2: A single-step strobe taken while feat_en is 1 issues a trace request (req_kind 2'b01) with status 64'h0000_0000_4000_0000 (bit 33 only). siar is loaded with step_prev_ip.
- R3: A single-step strobe taken while feat_en is 0 issues a trace request with an all-zero status word and leaves siar unchanged.
- R4: A breakpoint strobe issues a trace request with status 64'h0000_0000_4010_0000 (bits 33 and 43).
- R5: A watchpoint strobe issues a data storage request (req_kind 2'b10) with a zero status word. dar is loaded with wpt_addr and dsisr with 64'h0000_0000_0040_0000 (bit 41 only).
- R6: msr_merged equals msr_in OR req_status for a trace request, and equals msr_in unchanged for a data storage request.
- R7: While feat_en is 0, breakpoint and watchpoint strobes are ignored: no request is raised and dar and dsisr keep their values.
- R8: When several sources are available at once, the watchpoint issues first, then the breakpoint, then the single step. Every event is issued exactly once.
- R9: While req_valid is 1 and req_ready is 0, req_valid, req_kind and req_status hold. Events that arrive meanwhile are issued after acceptance.
- R10: A strobe sampled at clock edge k makes req_valid and the loaded registers visible right after edge k, with no added latency.
- R11: With req_ready held at 1, queued requests issue on consecutive cycles with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Extended debug reporting enable |
| step_valid | input | 1 | Single-step completion strobe |
| step_prev_ip | input | 64 | Address of the instruction just completed |
| bkpt_hit | input | 1 | Instruction-breakpoint hit strobe |
| wpt_hit | input | 1 | Data-watchpoint hit strobe |
| wpt_addr | input | 64 | Data address that matched the watchpoint |
| msr_in | input | 64 | Saved machine-state image before merging |
| req_ready | input | 1 | Core accepts the current request |
| req_valid | output | 1 | Exception request present |
| req_kind | output | 2 | 01 trace, 10 data storage |
| req_status | output | 64 | Status word of the request |
| msr_merged | output | 64 | Machine-state image with trace status merged |
| siar | output | 64 | Sampled-instruction-address register |
| dar | output | 64 | Data-address register |
| dsisr | output | 64 | Data-status register |

## Verification
The bench puts all three sources into the same cycle to check the issue order. A design with the wrong priority would report the breakpoint or the step before the watchpoint, or would drop one of them. It stalls the stream while a watchpoint arrives, then checks that dar stays at its old value until the watchpoint itself issues. A design that loads registers at capture time rather than at issue would expose the new address early. It drives a step with the feature off, and breakpoint and watchpoint strobes with the feature off. A design that set bit 33 regardless of the feature, or that still reported the masked strobes, would show a wrong status word or an unexpected data storage request. It also drains a full queue with ready held high, which catches an idle cycle inserted after each acceptance.

// File: rtl/dbg_excp_pkg.sv
package dbg_excp_pkg;
  typedef enum logic [1:0] {
    EXC_NONE  = 2'b00,
    EXC_TRACE = 2'b01,
    EXC_DSTOR = 2'b10
  } exc_kind_e;

  // source indices; a lower index wins arbitration
  localparam int SRC_N    = 3;
  localparam int SRC_WPT  = 0;
  localparam int SRC_BKPT = 1;
  localparam int SRC_STEP = 2;

  // big-endian bit numbers inside the status and data-status words
  localparam int STEP_BIT = 33;
  localparam int BKPT_BIT = 43;
  localparam int WPT_BIT  = 41;
endpackage

// File: rtl/dbg_evt_flag.sv
module dbg_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic take,
  output logic avail,
  output logic pend,
  output logic load
);
  logic pend_q;

  // an event is offered either from the slot or straight from the strobe
  assign avail = pend_q | strobe;
  assign pend  = pend_q;
  // a strobe becomes pending when it is not consumed directly
  assign load  = take ? (pend_q & strobe) : (strobe & ~pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (take) begin
      pend_q <= pend_q & strobe;
    end else if (strobe) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_evt_slot.sv
module dbg_evt_slot #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data_in,
  input  logic              take,
  output logic              avail,
  output logic              pend,
  output logic [DATA_W-1:0] data_out
);
  logic              load;
  logic [DATA_W-1:0] data_q;

  dbg_evt_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .take   (take),
    .avail  (avail),
    .pend   (pend),
    .load   (load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= data_in;
    end
  end

  assign data_out = pend ? data_q : data_in;
endmodule

// File: rtl/dbg_excp_arb.sv
module dbg_excp_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] avail,
  input  logic         can_issue,
  output logic [N-1:0] grant
);
  // fixed priority, index 0 highest
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = can_issue & avail[i];
    end else begin : g_rest
      assign grant[i] = can_issue & avail[i] & ~(|avail[i-1:0]);
    end
  end
endmodule

// File: rtl/dbg_excp_regs.sv
module dbg_excp_regs
  import dbg_excp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  grant,
  input  logic [ADDR_W:0]   step_word,
  input  logic [ADDR_W-1:0] wpt_word,
  input  logic              req_ready,
  output logic              can_issue,
  output logic              req_valid,
  output exc_kind_e         req_kind,
  output logic [STAT_W-1:0] req_status,
  output logic [ADDR_W-1:0] siar,
  output logic [ADDR_W-1:0] dar,
  output logic [STAT_W-1:0] dsisr
);
  localparam logic [STAT_W-1:0] ONE     = STAT_W'(1);
  localparam logic [STAT_W-1:0] ST_STEP = ONE << (STAT_W - 1 - STEP_BIT);
  localparam logic [STAT_W-1:0] ST_BKPT = ST_STEP | (ONE << (STAT_W - 1 - BKPT_BIT));
  localparam logic [STAT_W-1:0] DS_WPT  = ONE << (STAT_W - 1 - WPT_BIT);

  logic              valid_q;
  exc_kind_e         kind_q;
  logic [STAT_W-1:0] status_q;
  logic [ADDR_W-1:0] siar_q;
  logic [ADDR_W-1:0] dar_q;
  logic [STAT_W-1:0] dsisr_q;
  logic              step_en;
  logic [ADDR_W-1:0] step_ip;

  assign step_en   = step_word[ADDR_W];
  assign step_ip   = step_word[ADDR_W-1:0];
  assign can_issue = ~valid_q | req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      kind_q   <= EXC_NONE;
      status_q <= '0;
      siar_q   <= '0;
      dar_q    <= '0;
      dsisr_q  <= '0;
    end else if (|grant) begin
      valid_q <= 1'b1;
      if (grant[SRC_WPT]) begin
        kind_q   <= EXC_DSTOR;
        status_q <= '0;
        dar_q    <= wpt_word;
        dsisr_q  <= DS_WPT;
      end else if (grant[SRC_BKPT]) begin
        kind_q   <= EXC_TRACE;
        status_q <= ST_BKPT;
      end else begin
        kind_q   <= EXC_TRACE;
        status_q <= step_en ? ST_STEP : '0;
        if (step_en) begin
          siar_q <= step_ip;
        end
      end
    end else if (req_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign req_valid  = valid_q;
  assign req_kind   = kind_q;
  assign req_status = status_q;
  assign siar       = siar_q;
  assign dar        = dar_q;
  assign dsisr      = dsisr_q;
endmodule

// File: rtl/dbg_excp_unit.sv
module dbg_excp_unit
  import dbg_excp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              step_valid,
  input  logic [ADDR_W-1:0] step_prev_ip,
  input  logic              bkpt_hit,
  input  logic              wpt_hit,
  input  logic [ADDR_W-1:0] wpt_addr,
  input  logic [STAT_W-1:0] msr_in,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [STAT_W-1:0] req_status,
  output logic [STAT_W-1:0] msr_merged,
  output logic [ADDR_W-1:0] siar,
  output logic [ADDR_W-1:0] dar,
  output logic [STAT_W-1:0] dsisr
);
  localparam int STEP_W = ADDR_W + 1;

  logic [SRC_N-1:0] src_avail;
  logic [SRC_N-1:0] src_pend;
  logic [SRC_N-1:0] grant;
  logic             can_issue;
  logic [STEP_W-1:0] step_word;
  logic [ADDR_W-1:0] wpt_word;
  exc_kind_e         kind_w;

  // breakpoint and watchpoint strobes only count with the feature on
  dbg_evt_slot #(.DATA_W(ADDR_W)) u_wpt (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (wpt_hit & feat_en),
    .data_in  (wpt_addr),
    .take     (grant[SRC_WPT]),
    .avail    (src_avail[SRC_WPT]),
    .pend     (src_pend[SRC_WPT]),
    .data_out (wpt_word)
  );

  dbg_evt_flag u_bkpt (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (bkpt_hit & feat_en),
    .take   (grant[SRC_BKPT]),
    .avail  (src_avail[SRC_BKPT]),
    .pend   (src_pend[SRC_BKPT]),
    .load   ()
  );

  // the feature bit travels with the step so a later change cannot alter it
  dbg_evt_slot #(.DATA_W(STEP_W)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (step_valid),
    .data_in  ({feat_en, step_prev_ip}),
    .take     (grant[SRC_STEP]),
    .avail    (src_avail[SRC_STEP]),
    .pend     (src_pend[SRC_STEP]),
    .data_out (step_word)
  );

  dbg_excp_arb #(.N(SRC_N)) u_arb (
    .avail     (src_avail),
    .can_issue (can_issue),
    .grant     (grant)
  );

  dbg_excp_regs #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .step_word  (step_word),
    .wpt_word   (wpt_word),
    .req_ready  (req_ready),
    .can_issue  (can_issue),
    .req_valid  (req_valid),
    .req_kind   (kind_w),
    .req_status (req_status),
    .siar       (siar),
    .dar        (dar),
    .dsisr      (dsisr)
  );

  assign req_kind   = kind_w;
  assign msr_merged = (kind_w == EXC_TRACE) ? (msr_in | req_status) : msr_in;
endmodule

// File: rtl/dbg_excp_checker.sv
module dbg_excp_checker
  import dbg_excp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int STAT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feat_en,
  input logic              step_valid,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [STAT_W-1:0] req_status,
  input logic [STAT_W-1:0] msr_in,
  input logic [STAT_W-1:0] msr_merged,
  input logic [ADDR_W-1:0] siar,
  input logic [STAT_W-1:0] dsisr,
  input logic [SRC_N-1:0]  src_avail,
  input logic [SRC_N-1:0]  src_pend,
  input logic [SRC_N-1:0]  grant,
  input logic              can_issue
);
  localparam logic [STAT_W-1:0] DS_EXP = STAT_W'(1) << (STAT_W - 1 - WPT_BIT);

  // R9: a stalled request keeps its fields
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) && $stable(req_status));

  // R5: data storage request carries the fixed data-status pattern
  a_r5_dsisr_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == EXC_DSTOR |-> dsisr == DS_EXP && req_status == '0);

  // R6: no merge for a data storage request
  a_r6_no_merge_dstor: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == EXC_DSTOR |-> msr_merged == msr_in);

  // R3: a disabled step leaves the sampled address alone
  a_r3_siar_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_kind == EXC_TRACE && req_status == '0 |-> $stable(siar));

  // R7: with the feature off and no step or pending work, nothing is raised
  a_r7_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en && !step_valid && src_pend == '0 && !req_valid |=> !req_valid);

  // R8: the watchpoint wins whenever it is offered
  a_r8_wpt_first: assert property (@(posedge clk) disable iff (!rst_n)
    src_avail[SRC_WPT] && can_issue |=> req_valid && req_kind == EXC_DSTOR);

  // R8: at most one source is granted per cycle
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind dbg_excp_unit dbg_excp_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .feat_en    (feat_en),
  .step_valid (step_valid),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .req_status (req_status),
  .msr_in     (msr_in),
  .msr_merged (msr_merged),
  .siar       (siar),
  .dsisr      (dsisr),
  .src_avail  (src_avail),
  .src_pend   (src_pend),
  .grant      (grant),
  .can_issue  (can_issue)
);

// File: tb/dbg_excp_unit_test.sv
`timescale 1ns/1ps
module dbg_excp_unit_test;
  localparam logic [63:0] MSR_IN = 64'h8000_0000_0000_0011;
  localparam logic [63:0] S_STEP = 64'h0000_0000_4000_0000;
  localparam logic [63:0] S_BKPT = 64'h0000_0000_4010_0000;
  localparam logic [63:0] D_WPT  = 64'h0000_0000_0040_0000;
  localparam logic [1:0]  K_TR   = 2'b01;
  localparam logic [1:0]  K_DS   = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n, feat_en, step_valid, bkpt_hit, wpt_hit, req_ready;
  logic [63:0] step_prev_ip, wpt_addr, msr_in;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [63:0] req_status, msr_merged, siar, dar, dsisr;

  always #2.5 clk = ~clk;

  dbg_excp_unit uut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .step_valid(step_valid),
    .step_prev_ip(step_prev_ip), .bkpt_hit(bkpt_hit), .wpt_hit(wpt_hit),
    .wpt_addr(wpt_addr), .msr_in(msr_in), .req_ready(req_ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_status(req_status),
    .msr_merged(msr_merged), .siar(siar), .dar(dar), .dsisr(dsisr)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [63:0] status;
    logic [63:0] msr;
    logic [63:0] siar;
    logic [63:0] dar;
    logic [63:0] dsisr;
  } exp_t;

  exp_t        sb[$];
  string       tags[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [63:0] m_siar = '0, m_dar = '0, m_dsisr = '0;

  task automatic push(input logic [1:0] k, input logic [63:0] st, input string tag);
    exp_t e;
    e.kind   = k;
    e.status = st;
    e.msr    = (k == K_TR) ? (MSR_IN | st) : MSR_IN;
    e.siar   = m_siar;
    e.dar    = m_dar;
    e.dsisr  = m_dsisr;
    sb.push_back(e);
    tags.push_back(tag);
  endtask

  task automatic exp_step(input logic [63:0] ip, input bit en, input string tag);
    if (en) m_siar = ip;
    push(K_TR, en ? S_STEP : 64'h0, tag);
  endtask

  task automatic exp_bkpt(input string tag);
    push(K_TR, S_BKPT, tag);
  endtask

  task automatic exp_wpt(input logic [63:0] a, input string tag);
    m_dar = a;
    m_dsisr = D_WPT;
    push(K_DS, 64'h0, tag);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitor: compare every accepted request against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !done) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected request actual kind=%0d status=%h expected none",
                 req_kind, req_status);
      end else begin
        exp_t  e;
        string t;
        e = sb.pop_front();
        t = tags.pop_front();
        if (req_kind !== e.kind || req_status !== e.status || msr_merged !== e.msr ||
            siar !== e.siar || dar !== e.dar || dsisr !== e.dsisr) begin
          fails++;
          $display("FAIL %s actual kind=%0d st=%h msr=%h siar=%h dar=%h dsisr=%h expected kind=%0d st=%h msr=%h siar=%h dar=%h dsisr=%h",
                   t, req_kind, req_status, msr_merged, siar, dar, dsisr,
                   e.kind, e.status, e.msr, e.siar, e.dar, e.dsisr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    bit seen;
    rst_n = 0; feat_en = 1; step_valid = 0; bkpt_hit = 0; wpt_hit = 0;
    req_ready = 0; step_prev_ip = '0; wpt_addr = '0; msr_in = MSR_IN;
    repeat (4) tick();
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_valid == 0 && siar == 0 && dar == 0 && dsisr == 0, "R1 reset",
        {63'h0, req_valid} | siar | dar | dsisr, 64'h0);
    tick();
    req_ready = 1;

    // R2 enabled single step
    exp_step(64'h0000_7fff_0000_1000, 1, "R2 step enabled");
    step_valid = 1; step_prev_ip = 64'h0000_7fff_0000_1000;
    tick(); step_valid = 0;
    repeat (3) tick();

    // R3 disabled single step: zero status, siar kept
    feat_en = 0;
    exp_step(64'h0000_0000_dead_2000, 0, "R3 step disabled");
    step_valid = 1; step_prev_ip = 64'h0000_0000_dead_2000;
    tick(); step_valid = 0; feat_en = 1;
    repeat (3) tick();

    // R4 breakpoint and R6 merge
    exp_bkpt("R4 breakpoint / R6 merge");
    bkpt_hit = 1;
    tick(); bkpt_hit = 0;
    repeat (3) tick();

    // R5 watchpoint, R6 no merge
    exp_wpt(64'hc000_0000_0012_3458, "R5 watchpoint / R6 no merge");
    wpt_hit = 1; wpt_addr = 64'hc000_0000_0012_3458;
    tick(); wpt_hit = 0;
    repeat (3) tick();

    // R2 back-to-back steps
    exp_step(64'h1111_2222_3333_4444, 1, "R2 step b2b first");
    exp_step(64'h5555_6666_7777_8888, 1, "R2 step b2b second");
    step_valid = 1; step_prev_ip = 64'h1111_2222_3333_4444;
    tick(); step_prev_ip = 64'h5555_6666_7777_8888;
    tick(); step_valid = 0;
    repeat (3) tick();

    // R7 masked breakpoint and watchpoint
    feat_en = 0;
    bkpt_hit = 1; wpt_hit = 1; wpt_addr = 64'hffff_0000_ffff_0000;
    tick(); bkpt_hit = 0; wpt_hit = 0;
    seen = 0;
    repeat (4) begin
      @(negedge clk);
      seen |= req_valid;
    end
    chk(!seen && dar == 64'hc000_0000_0012_3458 && dsisr == D_WPT, "R7 masked strobes",
        dar, 64'hc000_0000_0012_3458);
    tick(); feat_en = 1;

    // R8 priority with all three in one cycle, R11 no bubbles
    exp_wpt(64'h0000_0000_0000_abc0, "R8 priority wpt");
    exp_bkpt("R8 priority bkpt");
    exp_step(64'h0000_0000_0040_0100, 1, "R8 priority step");
    wpt_hit = 1; wpt_addr = 64'h0000_0000_0000_abc0;
    bkpt_hit = 1; step_valid = 1; step_prev_ip = 64'h0000_0000_0040_0100;
    tick(); wpt_hit = 0; bkpt_hit = 0; step_valid = 0;
    hi = 0;
    repeat (3) begin
      @(negedge clk);
      hi += int'(req_valid);
    end
    chk(hi == 3, "R11 consecutive issue", 64'(hi), 64'd3);
    @(negedge clk);
    chk(req_valid == 0, "R11 drained", {63'h0, req_valid}, 64'h0);

    // R10 latency and R9 stall
    tick();
    req_ready = 0;
    exp_step(64'h0000_0000_0bad_c0de, 1, "R9 stalled step");
    step_valid = 1; step_prev_ip = 64'h0000_0000_0bad_c0de;
    @(negedge clk);
    chk(req_valid == 0, "R10 before edge", {63'h0, req_valid}, 64'h0);
    @(posedge clk); #1 step_valid = 0;
    @(negedge clk);
    chk(req_valid == 1 && siar == 64'h0000_0000_0bad_c0de && req_kind == K_TR,
        "R10 after edge", siar, 64'h0000_0000_0bad_c0de);
    tick();
    exp_wpt(64'h0000_0000_0000_5550, "R9 queued watchpoint");
    wpt_hit = 1; wpt_addr = 64'h0000_0000_0000_5550;
    tick(); wpt_hit = 0;
    repeat (3) tick();
    @(negedge clk);
    chk(req_valid == 1 && req_kind == K_TR && req_status == S_STEP &&
        dar == 64'h0000_0000_0000_abc0, "R9 hold while stalled", req_status, S_STEP);
    tick();
    req_ready = 1;
    repeat (6) tick();

    chk(sb.size() == 0, "R8 every event issued", 64'(sb.size()), 64'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule